// File: doc/BRIEF.md
# Four-Branch Generalized Feistel Block Cipher Core

This core encrypts or decrypts one 64-bit block under a 128-bit key. The state is split into four 16-bit branches. Each round feeds two of them through a keyed round function and folds the results into the other two. The round function is a key XOR, a layer of 4-bit S-boxes, a nibble-mixing linear layer and a second S-box layer. Nine rounds run back to back, and a 64-bit whitening key is XORed into the state before the first round and after the last.

The core evaluates one round per clock. Round keys are formed on the fly from the latched master key and a fixed 32-bit seed constant. A caller presents the block, the key and the direction, and raises `start` for one cycle while `busy` is low. The result appears on `blockOut` together with a one-cycle `done` pulse, and it stays there until the next operation finishes. Decryption uses the same round hardware with the keys in reverse order and the branch rotation undone, so it returns the original plaintext.

Top module: `tgfCipher`

## Requirements
- R1: While reset (`rstN` low) is applied and immediately after it, `busy` and `done` are 0 and `blockOut` is all zeros.
- R2: When `start` is sampled high at a rising edge with `busy` low, the start is accepted. `busy` is 1 during the 10 cycles that follow that edge. In the 11th cycle `done` is 1 for exactly one cycle and `busy` is 0. Every accepted start produces exactly one `done`.
- R3: A `start` sampled while `busy` is 1 has no effect. The running operation keeps its timing and its result, and no extra `done` follows.
- R4: Encryption: branches are B0=state[63:48], B1=[47:32], B2=[31:16] and B3=[15:0]. State = plaintext XOR K0. Each round r=1..9 XORs F(B0, rk_r[31:16]) into B1 and F(B2, rk_r[15:0]) into B3. Rounds 1..8 then rotate the branches one place left, so (B0,B1,B2,B3) becomes (B1,B2,B3,B0). Round 9 does not rotate. Ciphertext = state XOR K10.
- R5: F(x,k): a = x XOR k. Each nibble of a passes through the S-box S = {7,C,E,9,2,1,5,F,B,6,D,0,4,8,A,3} (input 0..F). Each result nibble is then replaced by the XOR of the other three result nibbles, and every nibble passes through S again.
- R6: The master key words are MK0..MK7, with MKw = key[127-16w -: 16]. Pair j = {MK[j mod 8], MK[(j+3) mod 8]} XOR (32'h9E3779B9 * (j+1) mod 2^32). The round key is rk_r = pair r, K0 = {pair 0, pair 10} and K10 = {pair 11, pair 12}.
- R7: Decryption (`decrypt`=1) inverts R4 exactly. It XORs in K10, runs the rounds with keys pair 9 down to pair 1 and rotates the branches right before every round except the first, then XORs in K0. Decrypting a ciphertext under the same key returns the plaintext.
- R8: A `start` given in the cycle in which `done` is high is accepted and begins a new operation with full R2 timing.
- R9: `blockIn`, `keyIn` and `decrypt` are sampled only at the accepting edge, so changing them during an operation does not alter its result. `blockOut` changes only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted when not busy) |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt, sampled with start |
| blockIn | input | 64 | Plaintext or ciphertext, sampled with start |
| keyIn | input | 128 | Master key, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: blockOut holds a new result |
| blockOut | output | 64 | Result of the last completed operation |

## Verification
The bench compares results against an independent model on extreme patterns: an all-zero block and key, all ones, a single set plaintext bit and a single set key bit. A wrong S-box, mixing layer or key pair would show up there as a different ciphertext. Each ciphertext is then decrypted. A rotation applied in the wrong place, or missing from the last round, would still look plausible on encryption but would fail to return the plaintext. The bench also raises `start` mid-operation with different data, and a core that re-accepted it would restart or corrupt the result or give a second `done`. A start in the `done` cycle checks that the core does not miss or delay a back-to-back request. Inputs are scrambled after each start, so an unlatched key or direction would corrupt the result.

// File: rtl/tgfPkg.sv
package tgfPkg;
  localparam int BR_W  = 16;
  localparam int NBR   = 4;
  localparam int BLK_W = BR_W * NBR;
  localparam int KEY_W = 128;
  localparam int MK_W  = 16;
  localparam int NMK   = KEY_W / MK_W;
  localparam int NIB_W = 4;
  localparam int IDX_W = 4;

  typedef logic [BR_W-1:0]    branch_t;
  typedef logic [BLK_W-1:0]   block_t;
  typedef logic [KEY_W-1:0]   key_t;
  typedef logic [2*BR_W-1:0]  rkey_t;

  typedef struct packed {
    logic load;
    logic round;
    logic finish;
    logic decMode;
    logic firstRnd;
    logic lastRnd;
  } ctrlStrobe_t;

  function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] r;
    case (n)
      4'h0: r = 4'h7;  4'h1: r = 4'hC;  4'h2: r = 4'hE;  4'h3: r = 4'h9;
      4'h4: r = 4'h2;  4'h5: r = 4'h1;  4'h6: r = 4'h5;  4'h7: r = 4'hF;
      4'h8: r = 4'hB;  4'h9: r = 4'h6;  4'hA: r = 4'hD;  4'hB: r = 4'h0;
      4'hC: r = 4'h4;  4'hD: r = 4'h8;  4'hE: r = 4'hA;  default: r = 4'h3;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tgfRoundF.sv
module tgfRoundF
  import tgfPkg::*;
(
  input  branch_t x,
  input  branch_t k,
  output branch_t y
);
  localparam int NNIB = BR_W / NIB_W;

  branch_t mixIn;
  branch_t sub1;
  branch_t spread;
  logic [NIB_W-1:0] par;

  assign mixIn = x ^ k;

  genvar i;
  generate
    for (i = 0; i < NNIB; i++) begin : gSub1
      assign sub1[i*NIB_W +: NIB_W] = sbox4(mixIn[i*NIB_W +: NIB_W]);
    end
  endgenerate

  always_comb begin
    par = '0;
    for (int n = 0; n < NNIB; n++) par = par ^ sub1[n*NIB_W +: NIB_W];
  end

  generate
    for (i = 0; i < NNIB; i++) begin : gSub2
      assign spread[i*NIB_W +: NIB_W] = par ^ sub1[i*NIB_W +: NIB_W];
      assign y[i*NIB_W +: NIB_W]      = sbox4(spread[i*NIB_W +: NIB_W]);
    end
  endgenerate
endmodule

// File: rtl/tgfKeySched.sv
module tgfKeySched
  import tgfPkg::*;
#(
  parameter int    ROUNDS  = 9,
  parameter rkey_t CK_SEED = 32'h9E3779B9
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             decMode,
  input  logic [IDX_W-1:0] rndIdx,
  input  key_t             keyIn,
  output rkey_t            rk,
  output block_t           wk
);
  localparam int NPAIR = ROUNDS + 4;

  key_t  keyQ;
  key_t  srcKey;
  rkey_t pairs [NPAIR];
  logic  useFront;
  logic [IDX_W:0] pick;

  assign srcKey = load ? keyIn : keyQ;

  genvar j;
  generate
    for (j = 0; j < NPAIR; j++) begin : gPair
      localparam int    W0  = j % NMK;
      localparam int    W1  = (j + 3) % NMK;
      localparam rkey_t CKJ = rkey_t'(CK_SEED * (j + 1));
      assign pairs[j] = {srcKey[KEY_W-1-W0*MK_W -: MK_W],
                         srcKey[KEY_W-1-W1*MK_W -: MK_W]} ^ CKJ;
    end
  endgenerate

  always_comb begin
    pick = decMode ? ((IDX_W+1)'(ROUNDS + 1) - {1'b0, rndIdx}) : {1'b0, rndIdx};
    rk = pairs[0];
    for (int n = 0; n < NPAIR; n++) begin
      if (pick == (IDX_W+1)'(n)) rk = pairs[n];
    end
  end

  assign useFront = load ? !decMode : decMode;
  assign wk = useFront ? {pairs[0], pairs[ROUNDS+1]}
                       : {pairs[ROUNDS+2], pairs[ROUNDS+3]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     keyQ <= '0;
    else if (load) keyQ <= keyIn;
  end
endmodule

// File: rtl/tgfDatapath.sv
module tgfDatapath
  import tgfPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t ctrl,
  input  block_t      blockIn,
  input  rkey_t       rk,
  input  block_t      wk,
  output block_t      blockOut
);
  block_t stateQ;
  block_t outQ;
  block_t mixIn;
  block_t mixOut;
  block_t nextState;

  assign mixIn = (ctrl.decMode && !ctrl.firstRnd)
               ? {stateQ[BR_W-1:0], stateQ[BLK_W-1:BR_W]}
               : stateQ;

  genvar p;
  generate
    for (p = 0; p < NBR/2; p++) begin : gPair
      localparam int HI = BLK_W - 1 - 2*p*BR_W;
      branch_t evenB;
      branch_t fOut;
      assign evenB = mixIn[HI -: BR_W];
      tgfRoundF u_f (
        .x(evenB),
        .k(rk[2*BR_W-1-p*BR_W -: BR_W]),
        .y(fOut)
      );
      assign mixOut[HI -: BR_W]        = evenB;
      assign mixOut[HI-BR_W -: BR_W]   = mixIn[HI-BR_W -: BR_W] ^ fOut;
    end
  endgenerate

  assign nextState = (!ctrl.decMode && !ctrl.lastRnd)
                   ? {mixOut[BLK_W-BR_W-1:0], mixOut[BLK_W-1 -: BR_W]}
                   : mixOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
      outQ   <= '0;
    end else begin
      if (ctrl.load)       stateQ <= blockIn ^ wk;
      else if (ctrl.round) stateQ <= nextState;
      if (ctrl.finish)     outQ   <= stateQ ^ wk;
    end
  end

  assign blockOut = outQ;
endmodule

// File: rtl/tgfControl.sv
module tgfControl
  import tgfPkg::*;
#(
  parameter int ROUNDS = 9
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             decrypt,
  output ctrlStrobe_t      ctrl,
  output logic [IDX_W-1:0] rndIdx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_RND = IDX_W'(ROUNDS);
  localparam logic [IDX_W-1:0] FIN_CNT  = IDX_W'(ROUNDS + 1);

  logic             busyQ;
  logic             modeQ;
  logic             doneQ;
  logic [IDX_W-1:0] cntQ;
  logic             accept;

  always_comb begin
    accept        = start && !busyQ;
    ctrl.load     = accept;
    ctrl.round    = busyQ && (cntQ != FIN_CNT);
    ctrl.finish   = busyQ && (cntQ == FIN_CNT);
    ctrl.decMode  = accept ? decrypt : modeQ;
    ctrl.firstRnd = (cntQ == IDX_W'(1));
    ctrl.lastRnd  = (cntQ == LAST_RND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      modeQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= ctrl.finish;
      if (accept) begin
        busyQ <= 1'b1;
        cntQ  <= IDX_W'(1);
        modeQ <= decrypt;
      end else if (ctrl.finish) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else if (busyQ) begin
        cntQ  <= cntQ + IDX_W'(1);
      end
    end
  end

  assign rndIdx = cntQ;
  assign busy   = busyQ;
  assign done   = doneQ;
endmodule

// File: rtl/tgfCipher.sv
module tgfCipher
  import tgfPkg::*;
#(
  parameter int    ROUNDS  = 9,
  parameter rkey_t CK_SEED = 32'h9E3779B9
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             decrypt,
  input  logic [BLK_W-1:0] blockIn,
  input  logic [KEY_W-1:0] keyIn,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] blockOut
);
  ctrlStrobe_t      ctrl;
  logic [IDX_W-1:0] rndIdx;
  rkey_t            rk;
  block_t           wk;

  tgfControl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .ctrl(ctrl), .rndIdx(rndIdx), .busy(busy), .done(done)
  );

  tgfKeySched #(.ROUNDS(ROUNDS), .CK_SEED(CK_SEED)) u_keys (
    .clk(clk), .rstN(rstN), .load(ctrl.load), .decMode(ctrl.decMode),
    .rndIdx(rndIdx), .keyIn(keyIn), .rk(rk), .wk(wk)
  );

  tgfDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .blockIn(blockIn),
    .rk(rk), .wk(wk), .blockOut(blockOut)
  );
endmodule

// File: rtl/tgfChecker.sv
module tgfChecker #(
  parameter int ROUNDS = 9
)(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [63:0] blockOut
);
  localparam logic [4:0] DONE_AT = 5'(ROUNDS + 2);
  localparam logic [4:0] BUSY_TO = 5'(ROUNDS + 1);
  localparam logic [4:0] LATE_ST = 5'(ROUNDS);

  logic       trk;
  logic [4:0] trkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trk    <= 1'b0;
      trkCnt <= '0;
    end else if (start && !busy) begin
      trk    <= 1'b1;
      trkCnt <= 5'd1;
    end else if (done) begin
      trk    <= 1'b0;
      trkCnt <= '0;
    end else if (trk) begin
      trkCnt <= trkCnt + 5'd1;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (trk && trkCnt == DONE_AT));

  p_busy_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trk && trkCnt <= BUSY_TO) |-> (busy && !done));

  p_ignore_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && trk && trkCnt <= LATE_ST) |=> busy);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(blockOut));
endmodule

bind tgfCipher tgfChecker #(.ROUNDS(ROUNDS)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .blockOut(blockOut)
);

// File: tb/test_tgfCipher.sv
`timescale 1ns/1ps
module test_tgfCipher;
  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic         decrypt;
  logic [63:0]  blockIn;
  logic [127:0] keyIn;
  logic         busy;
  logic         done;
  logic [63:0]  blockOut;

  int vecCount  = 0;
  int missCount = 0;
  logic [63:0] expQ[$];
  string       tagQ[$];
  logic [63:0] lastExp;

  always #10 clk = ~clk;

  tgfCipher i_tgfCipher (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .blockIn(blockIn), .keyIn(keyIn), .busy(busy), .done(done),
    .blockOut(blockOut)
  );

  // ---------------- reference model (from R4..R7) ----------------
  function automatic logic [3:0] refSbox(input logic [3:0] v);
    logic [3:0] t [16] = '{4'h7,4'hC,4'hE,4'h9,4'h2,4'h1,4'h5,4'hF,
                           4'hB,4'h6,4'hD,4'h0,4'h4,4'h8,4'hA,4'h3};
    return t[v];
  endfunction

  function automatic logic [15:0] refF(input logic [15:0] x, input logic [15:0] k);
    logic [15:0] a, b, c;
    logic [3:0]  p;
    a = x ^ k;
    for (int i = 0; i < 4; i++) b[4*i +: 4] = refSbox(a[4*i +: 4]);
    p = b[3:0] ^ b[7:4] ^ b[11:8] ^ b[15:12];
    for (int i = 0; i < 4; i++) c[4*i +: 4] = refSbox(p ^ b[4*i +: 4]);
    return c;
  endfunction

  function automatic logic [31:0] refPair(input logic [127:0] key, input int j);
    logic [15:0] w0, w1;
    logic [31:0] cst;
    w0  = key[127 - 16*(j % 8) -: 16];
    w1  = key[127 - 16*((j + 3) % 8) -: 16];
    cst = 32'h9E3779B9 * (j + 1);
    return {w0, w1} ^ cst;
  endfunction

  function automatic logic [63:0] refMix(input logic [63:0] s, input logic [31:0] rk);
    return {s[63:48], s[47:32] ^ refF(s[63:48], rk[31:16]),
            s[31:16], s[15:0]  ^ refF(s[31:16], rk[15:0])};
  endfunction

  function automatic logic [63:0] refEnc(input logic [63:0] pt, input logic [127:0] key);
    logic [63:0] s, y;
    s = pt ^ {refPair(key, 0), refPair(key, 10)};
    for (int r = 1; r <= 9; r++) begin
      y = refMix(s, refPair(key, r));
      s = (r < 9) ? {y[47:0], y[63:48]} : y;
    end
    return s ^ {refPair(key, 11), refPair(key, 12)};
  endfunction

  function automatic logic [63:0] refDec(input logic [63:0] ct, input logic [127:0] key);
    logic [63:0] s, x;
    s = ct ^ {refPair(key, 11), refPair(key, 12)};
    for (int d = 1; d <= 9; d++) begin
      x = (d == 1) ? s : {s[15:0], s[63:16]};
      s = refMix(x, refPair(key, 10 - d));
    end
    return s ^ {refPair(key, 0), refPair(key, 10)};
  endfunction

  // ---------------- checking ----------------
  task automatic note(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin : mon
    logic [63:0] e;
    string t;
    if (rstN === 1'b1 && done === 1'b1) begin
      if (expQ.size() == 0) begin
        note(1'b0, "R3", "done without pending operation", blockOut, 64'h0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        note(blockOut === e, t, "result", blockOut, e);
      end
    end
  end

  // driver: called at a negedge with busy low; returns at the next negedge
  task automatic launch(input logic [63:0] pt, input logic [127:0] key,
                        input bit dec, input logic [63:0] exp, input string tag);
    blockIn = pt;
    keyIn   = key;
    decrypt = dec;
    start   = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    lastExp = exp;
    @(negedge clk);
    start   = 1'b0;
    blockIn = ~pt;            // R9: later input changes must not matter
    keyIn   = ~key;
    decrypt = ~dec;
  endtask

  // launch plus R2 timing; returns at the done cycle
  task automatic timedOp(input logic [63:0] pt, input logic [127:0] key,
                         input bit dec, input logic [63:0] exp, input string tag);
    bit okBusy;
    launch(pt, key, dec, exp, tag);
    okBusy = busy && !done;
    for (int k = 2; k <= 10; k++) begin
      @(negedge clk);
      if (!(busy && !done)) okBusy = 1'b0;
    end
    note(okBusy, "R2", "busy window", {63'b0, okBusy}, 64'h1);
    @(negedge clk);
    note(done && !busy, "R2", "done cycle {done,busy}", {62'b0, done, busy}, 64'h2);
  endtask

  logic [63:0]  vPt  [5];
  logic [127:0] vKey [5];
  string        vTag [5];

  initial begin
    bit quiet;
    rstN = 1'b0; start = 1'b0; decrypt = 1'b0;
    blockIn = '0; keyIn = '0; lastExp = '0;
    vPt[0] = 64'h0;                vKey[0] = 128'h0;                                 vTag[0] = "R4";
    vPt[1] = 64'hFFFFFFFFFFFFFFFF; vKey[1] = {128{1'b1}};                            vTag[1] = "R5";
    vPt[2] = 64'h0123456789ABCDEF; vKey[2] = 128'h00112233445566778899AABBCCDDEEFF;  vTag[2] = "R4";
    vPt[3] = 64'h8000000000000000; vKey[3] = 128'h0;                                 vTag[3] = "R5";
    vPt[4] = 64'h0;                vKey[4] = 128'h1;                                 vTag[4] = "R6";

    repeat (3) @(negedge clk);
    note(busy == 1'b0, "R1", "busy in reset", {63'b0, busy}, 64'h0);
    note(done == 1'b0, "R1", "done in reset", {63'b0, done}, 64'h0);
    note(blockOut == 64'h0, "R1", "blockOut in reset", blockOut, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    note(!busy && !done && blockOut == 64'h0, "R1", "state after reset",
         blockOut, 64'h0);

    // encryption then decryption of each pattern
    for (int v = 0; v < 5; v++) begin
      timedOp(vPt[v], vKey[v], 1'b0, refEnc(vPt[v], vKey[v]), vTag[v]);
      @(negedge clk);
      note(!done, "R2", "done pulse width", {63'b0, done}, 64'h0);
      timedOp(refEnc(vPt[v], vKey[v]), vKey[v], 1'b1, vPt[v], "R7");
      @(negedge clk);
    end
    timedOp(64'hDEADBEEFCAFEF00D, vKey[2], 1'b1,
            refDec(64'hDEADBEEFCAFEF00D, vKey[2]), "R7");
    @(negedge clk);

    // R3: start while busy is ignored
    launch(64'h1122334455667788, vKey[2], 1'b0,
           refEnc(64'h1122334455667788, vKey[2]), "R3");
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; decrypt = 1'b1; blockIn = 64'hA5A5A5A5A5A5A5A5; keyIn = 128'h5;
    @(negedge clk);
    start = 1'b0;
    for (int k = 5; k <= 10; k++) @(negedge clk);
    @(negedge clk);
    note(done && !busy, "R3", "timing kept {done,busy}", {62'b0, done, busy}, 64'h2);
    quiet = 1'b1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (done || busy) quiet = 1'b0;
    end
    note(quiet, "R3", "no second operation", {63'b0, quiet}, 64'h1);

    // R8: back-to-back start in the done cycle
    timedOp(64'h0F0F0F0F0F0F0F0F, vKey[1], 1'b0,
            refEnc(64'h0F0F0F0F0F0F0F0F, vKey[1]), "R8");
    timedOp(64'h0F0F0F0F0F0F0F0F, vKey[3], 1'b1,
            refDec(64'h0F0F0F0F0F0F0F0F, vKey[3]), "R8");

    // R9: output holds while idle
    quiet = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || blockOut !== lastExp) quiet = 1'b0;
    end
    note(quiet, "R9", "blockOut held while idle", blockOut, lastExp);

    repeat (5) @(negedge clk);
    note(expQ.size() == 0, "R2", "operations without done", 64'(expQ.size()), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(64'd20 * 150000);
    missCount++;
    vecCount++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule